// File: doc/BRIEF.md
# Bytecode Program Counter Unit

This block holds the program counters that a bytecode interpreter uses. The running PC is a 24-bit byte address. It already contains the code base plus the logical offset, so an instruction-byte fetch needs no addition. The low 16 bits and the upper 8-bit extension are kept as one 24-bit value. An increment strobe steps the running PC by one byte. A load command writes the running PC and the fetch PC together.

When a new bytecode starts, the running PC is copied into a saved PC. A new bytecode is signalled by a dispatch that is qualified as trap-free, or by an unconditional dispatch. The saved PC is the base for relative jumps and the restart point after a trap. The unit adds a sign-extended 8-bit displacement to the low 16 bits of the saved PC to form a jump target. It also reports whether that jump leaves the current 256-byte page. The page-cross flag is built from the carry out of bit 7 together with the sign of the displacement.

Top module: `bc_pc_unit`

## Requirements
- R1: While rst_ni is low, pc_o, spc_o and fetch_pc_o are all zero.
- R2: When ld_i is high at a rising edge, pc_o and fetch_pc_o both take ld_val_i after that edge. ld_i has priority over inc_i.
- R3: When inc_i is high and ld_i is low at an edge, pc_o becomes its old value plus one. The carry runs across all 24 bits, and 0xFFFFFF wraps to 0.
- R4: When disp_i and no_trap_i are both high at an edge, spc_o takes the pc_o value from before that edge.
- R5: When disp_i is high and no_trap_i is low, and always_disp_i is low, spc_o does not change.
- R6: When always_disp_i is high at an edge, spc_o takes the pre-edge pc_o, whatever disp_i and no_trap_i are.
- R7: When a capture happens in the same cycle as inc_i or ld_i, spc_o gets the value from before the update.
- R8: jmp_tgt_o[15:0] equals spc_o[15:0] plus jdisp_i sign-extended to 16 bits, taken modulo 2^16. jmp_tgt_o[23:16] equals spc_o[23:16]. Both are combinational.
- R9: page_x_o is computed from c7, the carry out of bit 7 of spc_o[7:0]+jdisp_i. It equals c7 when jdisp_i[7] is 0, and the inverse of c7 when jdisp_i[7] is 1. This is the same as jmp_tgt_o[15:8] differing from spc_o[15:8].
- R10: fetch_pc_o changes only on ld_i. inc_i and captures leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load running and fetch PC |
| ld_val_i | input | 24 | Value for load |
| inc_i | input | 1 | Advance running PC one byte |
| disp_i | input | 1 | Dispatch strobe |
| no_trap_i | input | 1 | Qualifies dispatch as trap-free |
| always_disp_i | input | 1 | Unconditional dispatch |
| jdisp_i | input | 8 | Signed jump displacement |
| pc_o | output | 24 | Running PC |
| spc_o | output | 24 | Saved PC |
| fetch_pc_o | output | 24 | Fetch PC |
| jmp_tgt_o | output | 24 | Jump target |
| page_x_o | output | 1 | Jump crosses a 256-byte page |

## Verification
The hardest cases are page crossings with a negative displacement. There, a missing bit-7 carry is what signals the crossing, and that only shows for chosen pairs of saved-PC low byte and displacement. The stimulus first loads a chosen PC and captures it with an unconditional dispatch. It then sweeps displacements on both sides of the page boundary, in both signs, including -128. A second hard case is a capture that coincides with an increment, or with a 16-bit or 24-bit carry ripple. Both are reached by loading values just below those boundaries.

// File: rtl/bc_pc_pkg.sv
package bc_pc_pkg;
  parameter int unsigned PC_W   = 24;
  parameter int unsigned OFS_W  = 16;
  parameter int unsigned DISP_W = 8;
  typedef logic [PC_W-1:0] pc_t;
endpackage

// File: rtl/bc_pc_run.sv
module bc_pc_run
  import bc_pc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  pc_t  ld_val_i,
  input  logic inc_i,
  output pc_t  pc_o,
  output pc_t  fetch_pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o       <= '0;
      fetch_pc_o <= '0;
    end else if (ld_i) begin
      pc_o       <= ld_val_i;
      fetch_pc_o <= ld_val_i;
    end else if (inc_i) begin
      pc_o <= pc_o + pc_t'(1);
    end
  end

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (pc_o == $past(ld_val_i)) && (fetch_pc_o == $past(ld_val_i)));
  // R3
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i) |=> pc_o == pc_t'($past(pc_o) + 1));
  // R10
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(fetch_pc_o));
endmodule

// File: rtl/bc_pc_save.sv
module bc_pc_save
  import bc_pc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic disp_i,
  input  logic no_trap_i,
  input  logic always_disp_i,
  input  pc_t  pc_i,
  output pc_t  spc_o
);
  logic cap;
  assign cap = (disp_i & no_trap_i) | always_disp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  spc_o <= '0;
    else if (cap) spc_o <= pc_i;
  end

  // R4 R6 R7
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((disp_i && no_trap_i) || always_disp_i) |=> spc_o == $past(pc_i));
  // R5
  trap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!always_disp_i && !(disp_i && no_trap_i)) |=> $stable(spc_o));
endmodule

// File: rtl/bc_pc_jump.sv
module bc_pc_jump
  import bc_pc_pkg::*;
(
  input  pc_t               spc_i,
  input  logic [DISP_W-1:0] jdisp_i,
  output pc_t               tgt_o,
  output logic              page_x_o
);
  localparam int unsigned EXT_W = OFS_W - DISP_W;

  logic [OFS_W-1:0]  disp_sx;
  logic [OFS_W-1:0]  sum;
  logic [DISP_W:0]   low_sum;

  assign disp_sx = {{EXT_W{jdisp_i[DISP_W-1]}}, jdisp_i};
  assign sum     = spc_i[OFS_W-1:0] + disp_sx;
  // carry out of the low byte decides the crossing with the sign
  assign low_sum = {1'b0, spc_i[DISP_W-1:0]} + {1'b0, jdisp_i};
  assign page_x_o = low_sum[DISP_W] ^ jdisp_i[DISP_W-1];
  assign tgt_o    = {spc_i[PC_W-1:OFS_W], sum};
endmodule

// File: rtl/bc_pc_unit.sv
module bc_pc_unit
  import bc_pc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ld_i,
  input  logic [23:0] ld_val_i,
  input  logic        inc_i,
  input  logic        disp_i,
  input  logic        no_trap_i,
  input  logic        always_disp_i,
  input  logic [7:0]  jdisp_i,
  output logic [23:0] pc_o,
  output logic [23:0] spc_o,
  output logic [23:0] fetch_pc_o,
  output logic [23:0] jmp_tgt_o,
  output logic        page_x_o
);
  pc_t pc_q, spc_q;

  bc_pc_run i_run (
    .clk_i, .rst_ni, .ld_i, .ld_val_i, .inc_i,
    .pc_o(pc_q), .fetch_pc_o
  );

  bc_pc_save i_save (
    .clk_i, .rst_ni, .disp_i, .no_trap_i, .always_disp_i,
    .pc_i(pc_q), .spc_o(spc_q)
  );

  bc_pc_jump i_jump (
    .spc_i(spc_q), .jdisp_i, .tgt_o(jmp_tgt_o), .page_x_o
  );

  assign pc_o  = pc_q;
  assign spc_o = spc_q;

  // R9
  page_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_x_o == (jmp_tgt_o[15:8] != spc_o[15:8]));
  // R8
  tgt_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_tgt_o[23:16] == spc_o[23:16]);
endmodule

// File: tb/test_bc_pc_unit.sv
module test_bc_pc_unit;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic ld = 0, inc = 0, disp = 0, nt = 0, ad = 0;
  logic [23:0] ld_val = '0;
  logic [7:0]  jd = '0;
  logic [23:0] pc, spc, fpc, tgt;
  logic        px;
  int checks = 0, fails = 0;
  logic [23:0] e_pc = '0, e_spc = '0, e_fpc = '0;

  always #(CLK_P/2) clk = ~clk;

  bc_pc_unit i_bc_pc_unit (
    .clk_i(clk), .rst_ni(rst_n), .ld_i(ld), .ld_val_i(ld_val), .inc_i(inc),
    .disp_i(disp), .no_trap_i(nt), .always_disp_i(ad), .jdisp_i(jd),
    .pc_o(pc), .spc_o(spc), .fetch_pc_o(fpc), .jmp_tgt_o(tgt), .page_x_o(px)
  );

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one clock with given strobes; model updated from pre-edge values
  task automatic step(logic l, logic [23:0] v, logic i, logic d, logic n, logic a);
    logic [23:0] old_pc;
    @(negedge clk);
    ld = l; ld_val = v; inc = i; disp = d; nt = n; ad = a;
    @(posedge clk); #1;
    old_pc = e_pc;
    if (l) begin e_pc = v; e_fpc = v; end
    else if (i) e_pc = e_pc + 24'd1;
    if ((d && n) || a) e_spc = old_pc;
    ld = 0; inc = 0; disp = 0; nt = 0; ad = 0;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc, 24'h0);
    chk("R1 spc", spc, 24'h0);
    chk("R1 fpc", fpc, 24'h0);
  endtask

  task automatic t_load();
    step(1, 24'hA5_1234, 1, 0, 0, 0);
    chk("R2 pc", pc, 24'hA51234);
    chk("R2 fpc", fpc, 24'hA51234);
  endtask

  task automatic t_inc();
    step(0, 0, 1, 0, 0, 0);
    chk("R3 inc", pc, e_pc);
    chk("R10 fpc hold", fpc, 24'hA51234);
    step(1, 24'h12_FFFF, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R3 carry16", pc, 24'h130000);
    step(1, 24'hFF_FFFF, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R3 wrap", pc, 24'h000000);
  endtask

  task automatic t_dispatch();
    step(1, 24'h40_0100, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    chk("R4 save", spc, 24'h400100);
    step(1, 24'h40_0200, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk("R5 trap ignored", spc, 24'h400100);
    step(0, 0, 0, 0, 0, 1);
    chk("R6 always", spc, 24'h400200);
    step(0, 0, 1, 1, 1, 0);
    chk("R7 pre-inc", spc, 24'h400200);
    chk("R7 pc", pc, 24'h400201);
    step(1, 24'h77_0000, 0, 0, 0, 1);
    chk("R7 pre-load", spc, 24'h400201);
    chk("R10 fpc", fpc, 24'h770000);
    chk("model spc", spc, e_spc);
  endtask

  task automatic t_jump(logic [23:0] base);
    logic [7:0] ds [6] = '{8'h20, 8'hF0, 8'h80, 8'h7F, 8'h05, 8'hE0};
    logic [15:0] lo;
    step(1, base, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      jd = ds[k];
      #1;
      lo = base[15:0] + {{8{ds[k][7]}}, ds[k]};
      chk("R8 tgt", tgt, {base[23:16], lo});
      chk("R9 page", {23'b0, px}, {23'b0, lo[15:8] != base[15:8]});
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 3);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_load();
    t_inc();
    t_dispatch();
    t_jump(24'h12_34F0);
    t_jump(24'h12_3410);
    t_jump(24'h03_FF80);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule